// File: doc/BRIEF.md
# Flash Ready Status Poller

After a program or erase command has been sent to a parallel NOR flash, the device runs its internal operation on its own. This block finds out when that operation has finished. It reads one byte again and again from a fixed address through a simple request/data handshake and judges each byte with one of two completion schemes.

In toggle mode the status bit at position 6 flips on every read while the device is busy. The first read only records a reference value. Each later read is compared with the read just before it, and the operation is finished when two reads in a row agree. In data-polling mode, bit 7 of every read is compared with bit 7 of the byte that was programmed, and the operation is finished when the two bits match.

A wait, counted in clock cycles, can be placed before each comparison read. Erase operations are slow, so a long wait keeps the read traffic low; program operations use no wait. The number of comparison reads is capped. A finish that needed more reads than a second, lower threshold raises a warning together with the done pulse.

Top module: `flash_ready_poller`

## Requirements
- R1: After reset, `busy`, `done`, `timeout`, `slow_warn` and `rd_req` are all low.
- R2: Toggle mode (`mode_data`=0): the first read after start is only a reference. The operation completes on the first later read whose bit 6 equals bit 6 of the read just before it. All other bits of the read are ignored.
- R3: Data-polling mode (`mode_data`=1): the operation completes on the first read whose bit 7 equals bit 7 of `expect_byte`. All other bits are ignored.
- R4: `done` and `timeout` are pulses that last exactly one cycle. Each one rises in the cycle right after the clock edge at which the deciding read was accepted.
- R5: `addr_in` is captured when a start is accepted. Every read of that operation presents the captured value on `rd_addr`, even if `addr_in` changes later.
- R6: If MAX_ITER comparison reads pass without completion, `timeout` pulses, `done` stays low, and the block returns to idle.
- R7: `slow_warn` pulses together with `done` when the completing comparison read was number SLOW_ITER+1 or later. A finish on exactly read SLOW_ITER gives no warning. A timeout never gives a warning.
- R8: A `start` pulse while `busy` is high has no effect. The running operation keeps its address, its mode and its read count.
- R9: With `wait_cycles`=N, exactly N cycles with `rd_req` low come before every comparison read. The toggle reference read is issued at once. With N=0, reads follow each other back to back.
- R10: `rd_req` stays high from the moment it is raised until `rd_valid` is seen with it, and the byte on `rd_data` is taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins polling when idle |
| mode_data | input | 1 | 0 selects toggle mode, 1 selects data-polling mode |
| expect_byte | input | 8 | The byte that was programmed; bit 7 is used in data-polling mode |
| addr_in | input | AW | Address to poll |
| wait_cycles | input | DW | Idle cycles before each comparison read |
| rd_req | output | 1 | Read request, held until accepted |
| rd_addr | output | AW | Address of the requested read |
| rd_valid | input | 1 | Read data valid; accepts the pending request |
| rd_data | input | 8 | Byte returned by the read |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: operation finished |
| timeout | output | 1 | One-cycle pulse: gave up after the cap |
| slow_warn | output | 1 | One-cycle pulse with `done` when the finish was slow |

## Verification
The hardest cases are the two iteration limits. With the default thresholds near 2^28 and 2^20 reads, nobody can reach them in a bench. The bench therefore builds the block with MAX_ITER=8 and SLOW_ITER=3. It feeds scripted byte sequences: toggle streams that keep alternating, data streams with bit 7 held wrong, and finishes placed exactly on and just past the warning threshold. A read responder can also stall its grant, which checks that a request is held. A second start is pulsed in the middle of a waited operation and must be ignored.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_READ = 2'd2
    } poll_state_e;

    typedef enum logic {
        PM_TOGGLE = 1'b0,
        PM_DATA   = 1'b1
    } poll_mode_e;

    localparam int TOGGLE_BIT = 6;
    localparam int DATA_BIT   = 7;

endpackage

// File: rtl/poll_delay_cnt.sv
module poll_delay_cnt #(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          tick,
    output logic          last
);
    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (tick && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q <= DW'(1));

    // R9: the count only falls while the wait is running.
    a_r9_cnt_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/poll_iter_cnt.sv
module poll_iter_cnt #(
    parameter int unsigned MAX_ITER  = 32'h0FFF_FFFF,
    parameter int unsigned SLOW_ITER = 32'h0010_0000,
    localparam int IW = $clog2(MAX_ITER + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic          at_cap,
    output logic          over_slow
);
    logic [IW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // These flags describe the read that is being counted now (count + 1).
    assign at_cap    = (32'(cnt_q) >= MAX_ITER - 1);
    assign over_slow = (32'(cnt_q) >= SLOW_ITER);

    // R6: the count never passes the cap.
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) <= MAX_ITER);
endmodule

// File: rtl/poll_match.sv
module poll_match
    import flash_poll_pkg::*;
(
    input  poll_mode_e  mode,
    input  logic [7:0]  rd_byte,
    input  logic        ref_tog,
    input  logic        exp_msb,
    output logic        hit
);
    always_comb begin
        if (mode == PM_TOGGLE) hit = (rd_byte[TOGGLE_BIT] == ref_tog);
        else                   hit = (rd_byte[DATA_BIT]   == exp_msb);
    end
endmodule

// File: rtl/flash_ready_poller.sv
module flash_ready_poller
    import flash_poll_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 24,
    parameter int unsigned MAX_ITER  = 32'h0FFF_FFFF,
    parameter int unsigned SLOW_ITER = 32'h0010_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode_data,
    input  logic [7:0]    expect_byte,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wait_cycles,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_valid,
    input  logic [7:0]    rd_data,
    output logic          busy,
    output logic          done,
    output logic          timeout,
    output logic          slow_warn
);
    typedef struct packed {
        poll_state_e   state;
        poll_mode_e    mode;
        logic [AW-1:0] addr;
        logic [DW-1:0] wait_len;
        logic          exp_msb;
        logic          ref_tog;
        logic          first;
        logic          done;
        logic          tout;
        logic          warn;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic dly_load, dly_last, it_clr, it_inc, it_cap, it_slow, hit, go_next;
    logic [DW-1:0] dly_val;

    poll_delay_cnt #(.DW(DW)) u_delay (
        .clk(clk), .rst_n(rst_n), .load(dly_load), .load_val(dly_val),
        .tick(ctl_q.state == ST_WAIT), .last(dly_last));

    poll_iter_cnt #(.MAX_ITER(MAX_ITER), .SLOW_ITER(SLOW_ITER)) u_iter (
        .clk(clk), .rst_n(rst_n), .clr(it_clr), .inc(it_inc),
        .at_cap(it_cap), .over_slow(it_slow));

    poll_match u_match (
        .mode(ctl_q.mode), .rd_byte(rd_data), .ref_tog(ctl_q.ref_tog),
        .exp_msb(ctl_q.exp_msb), .hit(hit));

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.tout = 1'b0;
        ctl_d.warn = 1'b0;
        dly_load   = 1'b0;
        dly_val    = ctl_q.wait_len;
        it_clr     = 1'b0;
        it_inc     = 1'b0;
        go_next    = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: if (start) begin
                ctl_d.addr     = addr_in;
                ctl_d.mode     = poll_mode_e'(mode_data);
                ctl_d.exp_msb  = expect_byte[DATA_BIT];
                ctl_d.wait_len = wait_cycles;
                ctl_d.first    = !mode_data;
                it_clr         = 1'b1;
                if (!mode_data || wait_cycles == '0) begin
                    ctl_d.state = ST_READ;
                end else begin
                    ctl_d.state = ST_WAIT;
                    dly_load    = 1'b1;
                    dly_val     = wait_cycles;
                end
            end
            ST_WAIT: if (dly_last) ctl_d.state = ST_READ;
            ST_READ: if (rd_valid) begin
                ctl_d.ref_tog = rd_data[TOGGLE_BIT];
                ctl_d.first   = 1'b0;
                if (ctl_q.first) begin
                    go_next = 1'b1;
                end else begin
                    it_inc = 1'b1;
                    if (hit) begin
                        ctl_d.done  = 1'b1;
                        ctl_d.warn  = it_slow;
                        ctl_d.state = ST_IDLE;
                    end else if (it_cap) begin
                        ctl_d.tout  = 1'b1;
                        ctl_d.state = ST_IDLE;
                    end else begin
                        go_next = 1'b1;
                    end
                end
                if (go_next) begin
                    if (ctl_q.wait_len == '0) begin
                        ctl_d.state = ST_READ;
                    end else begin
                        ctl_d.state = ST_WAIT;
                        dly_load    = 1'b1;
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_req    = (ctl_q.state == ST_READ);
    assign rd_addr   = ctl_q.addr;
    assign busy      = (ctl_q.state != ST_IDLE);
    assign done      = ctl_q.done;
    assign timeout   = ctl_q.tout;
    assign slow_warn = ctl_q.warn;

    a_r4_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rd_req && rd_valid));
    a_r6_tout_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> $past(rd_req && rd_valid));
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done || timeout) |=> !(done || timeout));
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, timeout}));
    a_r7_warn_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        slow_warn |-> done);
    a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rd_addr));
    a_r8_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> rd_req);
    a_r1_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req);
endmodule

// File: tb/tb_flash_ready_poller.sv
module tb_flash_ready_poller;
    localparam int AW = 16;
    localparam int DW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, mode_data = 1'b0, rd_valid = 1'b0;
    logic [7:0] expect_byte = '0, rd_data = '0;
    logic [AW-1:0] addr_in = '0, rd_addr;
    logic [DW-1:0] wait_cycles = '0;
    logic rd_req, busy, done, timeout, slow_warn;

    always #2 clk = ~clk;

    flash_ready_poller #(.AW(AW), .DW(DW), .MAX_ITER(8), .SLOW_ITER(3)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_data(mode_data),
        .expect_byte(expect_byte), .addr_in(addr_in), .wait_cycles(wait_cycles),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .done(done), .timeout(timeout), .slow_warn(slow_warn));

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [7:0] script [10];
    int sidx, nreads, addr_err, lowrun, reqrun, hold, grant_cyc;
    int gaps [16];
    logic [AW-1:0] exp_addr;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Read responder: grants a held request after 'hold' extra cycles.
    initial begin
        sidx = 0; nreads = 0; addr_err = 0; lowrun = 0; reqrun = 0; hold = 0; grant_cyc = 0;
        forever begin
            @(negedge clk);
            if (rd_req && reqrun >= hold) begin
                rd_valid = 1'b1;
                rd_data  = script[sidx];
                if (sidx < 9) sidx++;
                if (rd_addr != exp_addr) addr_err++;
                if (nreads < 16) gaps[nreads] = lowrun;
                grant_cyc = cyc;
                nreads++;
                lowrun = 0;
                reqrun = 0;
            end else begin
                rd_valid = 1'b0;
                if (rd_req) reqrun++;
                else if (busy) lowrun++;
            end
        end
    end

    task automatic load_script(input logic [79:0] bytes);
        for (int i = 0; i < 10; i++) script[i] = bytes[79-8*i -: 8];
        sidx = 0; nreads = 0; addr_err = 0; lowrun = 0; reqrun = 0;
    endtask

    task automatic run_op(input logic md, input logic [7:0] eb, input logic [DW-1:0] wc,
                          input logic [AW-1:0] ad, output logic gd, output logic gt,
                          output logic gw, output int lat, output logic again);
        int k;
        exp_addr = ad;
        @(negedge clk);
        start = 1'b1; mode_data = md; expect_byte = eb; wait_cycles = wc; addr_in = ad;
        @(negedge clk);
        start = 1'b0; addr_in = ~ad; mode_data = ~md; wait_cycles = '0;
        k = 0;
        while (!(done || timeout) && k < 3000) begin
            @(negedge clk);
            k++;
        end
        gd = done; gt = timeout; gw = slow_warn; lat = cyc - grant_cyc;
        @(negedge clk);
        again = done || timeout;
    endtask

    typedef struct packed {
        logic        md;
        logic [7:0]  eb;
        logic [79:0] bytes;
        logic [7:0]  reads;
        logic        dn;
        logic        to;
        logic        wn;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{1'b0, 8'h00, 80'h00_40_40_40_40_40_40_40_40_40, 8'd3, 1'b1, 1'b0, 1'b0},
        '{1'b0, 8'h00, 80'h40_40_40_40_40_40_40_40_40_40, 8'd2, 1'b1, 1'b0, 1'b0},
        '{1'b0, 8'h00, 80'h00_40_00_40_00_00_00_00_00_00, 8'd6, 1'b1, 1'b0, 1'b1},
        '{1'b0, 8'h00, 80'h00_40_00_00_00_00_00_00_00_00, 8'd4, 1'b1, 1'b0, 1'b0},
        '{1'b0, 8'h00, 80'h00_40_00_40_00_40_00_40_00_40, 8'd9, 1'b0, 1'b1, 1'b0},
        '{1'b1, 8'h80, 80'h7F_00_80_80_80_80_80_80_80_80, 8'd3, 1'b1, 1'b0, 1'b0},
        '{1'b1, 8'h00, 80'hFF_7F_7F_7F_7F_7F_7F_7F_7F_7F, 8'd2, 1'b1, 1'b0, 1'b0},
        '{1'b1, 8'h80, 80'h00_00_00_00_00_00_00_00_00_00, 8'd8, 1'b0, 1'b1, 1'b0},
        '{1'b1, 8'h80, 80'h00_00_00_00_80_80_80_80_80_80, 8'd5, 1'b1, 1'b0, 1'b1},
        '{1'b0, 8'h00, 80'h00_BF_BF_BF_BF_BF_BF_BF_BF_BF, 8'd2, 1'b1, 1'b0, 1'b0},
        '{1'b1, 8'hFF, 80'h80_80_80_80_80_80_80_80_80_80, 8'd1, 1'b1, 1'b0, 1'b0}
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic gd, gt, gw, again;
        int lat;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !timeout && !slow_warn && !rd_req, "R1", 
            int'({busy, done, timeout, slow_warn, rd_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !rd_req, "R1", int'({busy, rd_req}), 0);

        // Table walk: R2, R3, R4, R5, R6, R7
        for (int v = 0; v < 11; v++) begin
            load_script(VECS[v].bytes);
            run_op(VECS[v].md, VECS[v].eb, '0, AW'(16'h0155 + 16'h0100 * v), gd, gt, gw, lat, again);
            chk(gd == VECS[v].dn, VECS[v].md ? "R3 done" : "R2 done", int'(gd), int'(VECS[v].dn));
            chk(gt == VECS[v].to, "R6 timeout", int'(gt), int'(VECS[v].to));
            chk(gw == VECS[v].wn, "R7 warn", int'(gw), int'(VECS[v].wn));
            chk(nreads == int'(VECS[v].reads), VECS[v].md ? "R3 reads" : "R2 reads",
                nreads, int'(VECS[v].reads));
            chk(addr_err == 0, "R5 address", addr_err, 0);
            chk(lat == 1 && !again, "R4 pulse", lat, 1);
        end

        // R9: toggle with wait 3, reference read immediate
        load_script(80'h00_40_40_40_40_40_40_40_40_40);
        run_op(1'b0, 8'h00, 8'd3, 16'h0AA0, gd, gt, gw, lat, again);
        chk(gaps[0] == 0, "R9 ref gap", gaps[0], 0);
        chk(gaps[1] == 3 && gaps[2] == 3, "R9 wait gap", gaps[1], 3);
        chk(gd && nreads == 3, "R9 done", nreads, 3);

        // R9: data polling with wait 2 before every read
        load_script(80'h00_80_80_80_80_80_80_80_80_80);
        run_op(1'b1, 8'h80, 8'd2, 16'h0BB0, gd, gt, gw, lat, again);
        chk(gaps[0] == 2 && gaps[1] == 2, "R9 data gap", gaps[0], 2);

        // R10: responder stalls 3 cycles per read, request must stay up
        hold = 3;
        load_script(80'h00_40_40_40_40_40_40_40_40_40);
        run_op(1'b0, 8'h00, 8'd0, 16'h0CC0, gd, gt, gw, lat, again);
        chk(gd && nreads == 3, "R10 reads", nreads, 3);
        chk(gaps[1] == 0 && gaps[2] == 0, "R10 held", gaps[1], 0);
        hold = 0;

        // R8: second start mid-operation is ignored
        load_script(80'h00_40_40_40_40_40_40_40_40_40);
        exp_addr = 16'h0DD0;
        @(negedge clk);
        start = 1'b1; mode_data = 1'b0; wait_cycles = 8'd4; addr_in = 16'h0DD0;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        start = 1'b1; mode_data = 1'b1; expect_byte = 8'h00; wait_cycles = 8'd0; addr_in = 16'h0EE0;
        @(negedge clk);
        start = 1'b0;
        begin
            int k = 0;
            while (!done && k < 200) begin @(negedge clk); k++; end
        end
        chk(done && nreads == 3, "R8 reads", nreads, 3);
        chk(addr_err == 0, "R8 address", addr_err, 0);
        repeat (4) @(negedge clk);
        chk(!busy && nreads == 3, "R8 no restart", nreads, 3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule